// File: doc/BRIEF.md
# PCI Capability List Registers

This block holds the part of a PCI function's configuration space that forms the capability linked list. That part is the list-present flag in the status word, the pointer to the first capability, the power management header with its link byte, and the hot swap header with its link byte. The list ends at a VPD header whose identifier is fixed. A few host-writable control bytes sit beside these headers: the command byte, the power management control/status word, the hot swap control byte and the VPD address word.

The host reaches the block through a configuration port. Each access names a dword index and carries four byte enables. Reads return the whole dword one cycle later. Writes change only the host-writable bytes whose lanes are enabled.

A second port is a byte-wide load strobe. It is fed by the EEPROM loader after reset, and it is the only way to change the list flag, the pointers and the hot swap identifier. Address decoding for both ports compares against fixed offsets and never against the loaded pointer values. As a result, a host write can never land in a capability register, even when a pointer has been reprogrammed.

Top module: `pci_caplist_regs`

## Requirements
- R1: After reset the block holds these values. The list flag (status word bit 4, read as bit 20 of dword 04h) is 1. The pointer at 34h is 40h. The power management link at 41h is 48h. The hot swap identifier at 48h is 06h. The hot swap link at 49h is 4Ch. All host-writable bytes are 0. The list therefore runs power management, then hot swap, then VPD.
- R2: A read with cfg_req=1 and cfg_we=0 raises cfg_rvalid in the next cycle, with cfg_rdata holding the dword at that index. The byte at offset 4n+k appears in bits [8k+7:8k]. cfg_rvalid is low in every other cycle.
- R3: Host writes never change the list flag, the pointer at 34h, the link at 41h, the hot swap identifier at 48h or the link at 49h, whatever the data or byte enables.
- R4: A load strobe (ee_wr=1) writes ee_data into the byte at ee_addr, and the value is readable from the next cycle. At 06h only bit 4 is kept. A loaded value of 0 at 48h or 49h reads back as 0: this switches hot swap off or ends the list before VPD.
- R5: A host write changes the byte at each enabled lane among the host-writable bytes (04h, 44h, 45h, 4Ah, 4Eh, 4Fh). Bytes in disabled lanes keep their values.
- R6: Host write decoding does not depend on loaded pointer values. With the pointer at 34h loaded as 48h and the link at 41h loaded as 44h, a host write to dword 44h changes only that dword.
- R7: Dword 40h reads the fixed identifier 01h in byte 0. Dword 4Ch reads 03h in byte 0 and 00h in byte 1. Host writes to these bytes have no effect.
- R8: Offsets that hold no register read as 0, both before and after host writes to them (for example dwords 00h, 08h, 50h, FCh and bytes 42h, 43h, 4Bh).
- R9: When a load strobe and a host write hit the same byte in the same cycle, the byte takes the loaded value.
- R10: ee_done is 0 after reset. It becomes 1 in the cycle after a load strobe with ee_last=1, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block leaves reset in step with clk |
| cfg_req | input | 1 | Host configuration access in this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | CFG_AW | Dword index (byte offset bits 7:2) |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Host write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the request |
| cfg_rdata | output | 32 | Read data |
| ee_wr | input | 1 | EEPROM load strobe, one byte per cycle |
| ee_addr | input | CFG_AW+2 | Byte offset of the load |
| ee_data | input | 8 | Byte to load |
| ee_last | input | 1 | Marks the final load strobe |
| ee_done | output | 1 | Sticky flag: loading has finished |

## Verification
The assertions check on every cycle that each byte changes only when the fixed decoder selects it. They also check that EEPROM-only fields stay put unless a load strobe arrives, that a load wins a same-cycle clash, that read-valid timing holds, and that the done flag is sticky. The bench scenarios cover what only a full sequence can show. Those are the reset contents, lane placement in the read data, and zero reads at unimplemented offsets. They also include the fixed identifiers, and the case where host writes stay at their own offsets after the pointers have been loaded with misleading values.

// File: rtl/pci_caplist_pkg.sv
package pci_caplist_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int NF    = 11;

  // field indices of stored bytes
  localparam int F_CMD   = 0;
  localparam int F_STAT  = 1;
  localparam int F_CPTR  = 2;
  localparam int F_PMNX  = 3;
  localparam int F_PMCS0 = 4;
  localparam int F_PMCS1 = 5;
  localparam int F_HSID  = 6;
  localparam int F_HSNX  = 7;
  localparam int F_HSCS  = 8;
  localparam int F_VPDA0 = 9;
  localparam int F_VPDA1 = 10;

  // fixed byte offset of each stored field
  function automatic logic [7:0] fld_off(input int f);
    case (f)
      F_CMD:   return 8'h04;
      F_STAT:  return 8'h06;
      F_CPTR:  return 8'h34;
      F_PMNX:  return 8'h41;
      F_PMCS0: return 8'h44;
      F_PMCS1: return 8'h45;
      F_HSID:  return 8'h48;
      F_HSNX:  return 8'h49;
      F_HSCS:  return 8'h4A;
      F_VPDA0: return 8'h4E;
      F_VPDA1: return 8'h4F;
      default: return 8'hFF;
    endcase
  endfunction

  // implemented bits of each field
  function automatic logic [7:0] fld_mask(input int f);
    return (f == F_STAT) ? 8'h10 : 8'hFF;
  endfunction

  // field may be written by the host port
  function automatic logic fld_host_wr(input int f);
    case (f)
      F_CMD, F_PMCS0, F_PMCS1, F_HSCS, F_VPDA0, F_VPDA1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // fixed identifier bytes (not stored)
  function automatic logic [7:0] const_byte(input logic [7:0] off);
    case (off)
      8'h40:   return 8'h01;
      8'h4C:   return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pci_caplist_dec.sv
module pci_caplist_dec
  import pci_caplist_pkg::*;
#(
  parameter int BAW = 8
) (
  input  logic           en,
  input  logic [BAW-1:0] baddr,
  output logic [NF-1:0]  hit
);

  for (genvar f = 0; f < NF; f++) begin : g_fld
    localparam logic [BAW-1:0] OFF = BAW'(fld_off(f));
    assign hit[f] = en && (baddr == OFF);
  end

endmodule

// File: rtl/pci_caplist_store.sv
module pci_caplist_store
  import pci_caplist_pkg::*;
#(
  parameter logic [8*NF-1:0] RST_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NF-1:0]   host_hit,
  input  logic [8*NF-1:0] host_byte,
  input  logic [NF-1:0]   ee_hit,
  input  logic [7:0]      ee_data,
  output logic [8*NF-1:0] q
);

  logic [NF-1:0]   en;
  logic [8*NF-1:0] d;

  // next-state: load path has priority over host path
  always_comb begin
    for (int f = 0; f < NF; f++) begin
      en[f] = ee_hit[f] | (host_hit[f] & fld_host_wr(f));
      if (ee_hit[f]) d[8*f +: 8] = ee_data & fld_mask(f);
      else           d[8*f +: 8] = host_byte[8*f +: 8] & fld_mask(f);
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[8*f +: 8] <= RST_VEC[8*f +: 8];
      else if (en[f]) q[8*f +: 8] <= d[8*f +: 8];
    end
  end

endmodule

// File: rtl/pci_caplist_rdmux.sv
module pci_caplist_rdmux
  import pci_caplist_pkg::*;
#(
  parameter int CFG_AW = 6
) (
  input  logic [CFG_AW-1:0] idx,
  input  logic [8*NF-1:0]   q,
  output logic [DW-1:0]     dword
);

  localparam int LB  = $clog2(LANES);
  localparam int BAW = CFG_AW + LB;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BAW-1:0] boff;
    logic [7:0]     lane_v;
    assign boff = {idx, LB'(l)};
    always_comb begin
      lane_v = const_byte(8'(boff));
      for (int f = 0; f < NF; f++)
        if (boff == BAW'(fld_off(f))) lane_v = lane_v | q[8*f +: 8];
    end
    assign dword[8*l +: 8] = lane_v;
  end

endmodule

// File: rtl/pci_caplist_regs.sv
module pci_caplist_regs
  import pci_caplist_pkg::*;
#(
  parameter int         CFG_AW   = 6,
  parameter logic [7:0] CPTR_RST = 8'h40,
  parameter logic [7:0] PMNX_RST = 8'h48,
  parameter logic [7:0] HSID_RST = 8'h06,
  parameter logic [7:0] HSNX_RST = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_rvalid,
  output logic [31:0]       cfg_rdata,
  input  logic              ee_wr,
  input  logic [CFG_AW+1:0] ee_addr,
  input  logic [7:0]        ee_data,
  input  logic              ee_last,
  output logic              ee_done
);

  localparam int LB  = $clog2(LANES);
  localparam int BAW = CFG_AW + LB;

  // reset image, field F_VPDA1 first down to F_CMD
  localparam logic [8*NF-1:0] RST_VEC = {
    8'h00, 8'h00, 8'h00, HSNX_RST, HSID_RST,
    8'h00, 8'h00, PMNX_RST, CPTR_RST, 8'h10, 8'h00};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  // host lane decoders, all at fixed offsets
  logic [NF-1:0] lane_hit [LANES];
  logic [NF-1:0] host_hit;
  logic [8*NF-1:0] host_byte;
  logic [NF-1:0] ee_hit;
  logic [8*NF-1:0] fld_q;

  for (genvar l = 0; l < LANES; l++) begin : g_hdec
    pci_caplist_dec #(.BAW(BAW)) u_dec (
      .en    (cfg_req && cfg_we && cfg_be[l]),
      .baddr ({cfg_addr, LB'(l)}),
      .hit   (lane_hit[l])
    );
  end

  always_comb begin
    host_hit = '0;
    for (int l = 0; l < LANES; l++) host_hit = host_hit | lane_hit[l];
  end

  for (genvar f = 0; f < NF; f++) begin : g_hbyte
    localparam int LN = int'(fld_off(f)) % LANES;
    assign host_byte[8*f +: 8] = cfg_wdata[8*LN +: 8];
  end

  pci_caplist_dec #(.BAW(BAW)) u_eedec (
    .en    (ee_wr),
    .baddr (ee_addr),
    .hit   (ee_hit)
  );

  pci_caplist_store #(.RST_VEC(RST_VEC)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .host_hit  (host_hit),
    .host_byte (host_byte),
    .ee_hit    (ee_hit),
    .ee_data   (ee_data),
    .q         (fld_q)
  );

  logic [DW-1:0] rd_dword;
  pci_caplist_rdmux #(.CFG_AW(CFG_AW)) u_rdmux (
    .idx   (cfg_addr),
    .q     (fld_q),
    .dword (rd_dword)
  );

  // read response and load-done next state
  logic          rd_en;
  logic          rvalid_d;
  logic          done_d;
  assign rd_en    = cfg_req && !cfg_we;
  assign rvalid_d = rd_en;
  assign done_d   = ee_done | (ee_wr & ee_last);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
      ee_done    <= 1'b0;
    end else begin
      cfg_rvalid <= rvalid_d;
      if (rd_en) cfg_rdata <= rd_dword;
      ee_done <= done_d;
    end
  end

endmodule

// File: rtl/pci_caplist_chk.sv
module pci_caplist_chk
  import pci_caplist_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_req,
  input logic            cfg_we,
  input logic            cfg_rvalid,
  input logic            ee_wr,
  input logic            ee_last,
  input logic            ee_done,
  input logic [7:0]      ee_data,
  input logic [NF-1:0]   host_hit,
  input logic [NF-1:0]   ee_hit,
  input logic [8*NF-1:0] host_byte,
  input logic [8*NF-1:0] fld_q
);

  // R2: read response timing
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we) |=> cfg_rvalid);
  a_r2_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && !cfg_we) |=> !cfg_rvalid);

  // R3: load-only fields hold without a load strobe
  a_r3_ptrs_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_wr |=> ($stable(fld_q[8*F_CPTR +: 8]) && $stable(fld_q[8*F_PMNX +: 8]) &&
                $stable(fld_q[8*F_STAT +: 8]) && $stable(fld_q[8*F_HSID +: 8]) &&
                $stable(fld_q[8*F_HSNX +: 8])));

  // R10: done flag
  a_r10_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_wr && ee_last) |=> ee_done);
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ee_done |=> ee_done);

  for (genvar f = 0; f < NF; f++) begin : g_f
    // R6: a byte moves only when the fixed decoder selects it
    a_r6_fixed_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_hit[f] && !ee_hit[f]) |=> $stable(fld_q[8*f +: 8]));
    // R4 / R9: a load lands, and wins over a same-cycle host write
    a_r4_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ee_hit[f] |=> fld_q[8*f +: 8] == ($past(ee_data) & fld_mask(f)));
    if (fld_host_wr(f)) begin : g_hw
      // R5: host write lands on its own byte
      a_r5_host_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (host_hit[f] && !ee_hit[f]) |=> fld_q[8*f +: 8] == $past(host_byte[8*f +: 8]));
    end
  end

endmodule

bind pci_caplist_regs pci_caplist_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_req    (cfg_req),
  .cfg_we     (cfg_we),
  .cfg_rvalid (cfg_rvalid),
  .ee_wr      (ee_wr),
  .ee_last    (ee_last),
  .ee_done    (ee_done),
  .ee_data    (ee_data),
  .host_hit   (host_hit),
  .ee_hit     (ee_hit),
  .host_byte  (host_byte),
  .fld_q      (fld_q)
);

// File: tb/pci_caplist_regs_bench.sv
`timescale 1ns/1ps
module pci_caplist_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic        ee_wr = 1'b0, ee_last = 1'b0;
  logic [7:0]  ee_addr = '0, ee_data = '0;
  logic        ee_done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  pci_caplist_regs u_pci_caplist_regs (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .ee_wr(ee_wr),
    .ee_addr(ee_addr), .ee_data(ee_data), .ee_last(ee_last), .ee_done(ee_done));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each read response with the scoreboard queue
  always @(negedge clk) begin
    if (cfg_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected rvalid", cfg_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cfg_rdata === e, t, cfg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = off[7:2];
    @(negedge clk);
    cfg_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = off[7:2]; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic ld(input logic [7:0] a, input logic [7:0] d, input bit last);
    @(negedge clk);
    ee_wr = 1'b1; ee_addr = a; ee_data = d; ee_last = last;
    @(negedge clk);
    ee_wr = 1'b0; ee_last = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ee_done === 1'b0, "R10 done after reset", {31'h0, ee_done}, 32'h0);

    // R1 / R2 / R7: reset contents and lane placement
    rd(8'h04, 32'h0010_0000, "R1 status list flag");
    rd(8'h34, 32'h0000_0040, "R1 cap pointer");
    rd(8'h40, 32'h0000_4801, "R1 R7 pm header");
    rd(8'h44, 32'h0000_0000, "R1 pm csr");
    rd(8'h48, 32'h0000_4C06, "R1 hs header");
    rd(8'h4C, 32'h0000_0003, "R1 R7 vpd header");

    // R3 / R5 / R7: host writes
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0010_00FF, "R3 R5 status bit kept, command written");
    wr(8'h34, 4'hF, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0000_0040, "R3 cap pointer host-immune");
    wr(8'h40, 4'hF, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0000_4801, "R3 R7 pm header host-immune");
    wr(8'h48, 4'hF, 32'hFFFF_FFFF);
    rd(8'h48, 32'h00FF_4C06, "R3 R5 hs ctrl only");
    wr(8'h4C, 4'hC, 32'hBEEF_5555);
    rd(8'h4C, 32'hBEEF_0003, "R5 R7 vpd addr lanes");
    wr(8'h44, 4'h1, 32'h1234_5603);
    rd(8'h44, 32'h0000_0003, "R5 disabled lanes kept");

    // R8: unimplemented offsets
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R8 dword 00h");
    rd(8'h08, 32'h0, "R8 dword 08h");
    wr(8'h50, 4'hF, 32'hFFFF_FFFF);
    rd(8'h50, 32'h0, "R8 dword 50h");
    rd(8'hFC, 32'h0, "R8 dword FCh");

    // R4: loads, status masking, zeroed hot swap headers
    ld(8'h06, 8'hFF, 1'b0);
    rd(8'h04, 32'h0010_00FF, "R4 status only bit 4");
    ld(8'h06, 8'h00, 1'b0);
    rd(8'h04, 32'h0000_00FF, "R4 list flag cleared");
    ld(8'h34, 8'h48, 1'b0);
    ld(8'h41, 8'h44, 1'b0);
    ld(8'h48, 8'h00, 1'b0);
    check(ee_done === 1'b0, "R10 done low before last", {31'h0, ee_done}, 32'h0);
    ld(8'h49, 8'h00, 1'b1);
    check(ee_done === 1'b1, "R10 done after last", {31'h0, ee_done}, 32'h1);
    rd(8'h34, 32'h0000_0048, "R4 cap pointer loaded");
    rd(8'h40, 32'h0000_4401, "R4 pm link loaded");
    rd(8'h48, 32'h00FF_0000, "R4 hs id and link zeroed");

    // R6: decode ignores the loaded pointers
    wr(8'h44, 4'h3, 32'hAAAA_0102);
    rd(8'h44, 32'h0000_0102, "R6 pm csr written");
    rd(8'h40, 32'h0000_4401, "R6 pm header untouched");
    rd(8'h48, 32'h00FF_0000, "R6 hs header untouched");
    rd(8'h34, 32'h0000_0048, "R6 pointer untouched");

    // R9: same-byte clash, load wins
    @(negedge clk);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = 6'h01; cfg_be = 4'h1; cfg_wdata = 32'h0000_0011;
    ee_wr = 1'b1; ee_addr = 8'h04; ee_data = 8'h5A;
    @(negedge clk);
    cfg_addr = 6'h12; cfg_be = 4'h4; cfg_wdata = 32'h0077_0000;
    ee_addr = 8'h4A; ee_data = 8'h33;
    @(negedge clk);
    cfg_req = 1'b0; cfg_we = 1'b0; cfg_be = '0; ee_wr = 1'b0;
    rd(8'h04, 32'h0000_005A, "R9 command clash");
    rd(8'h48, 32'h0033_0000, "R9 hs ctrl clash");
    check(ee_done === 1'b1, "R10 done sticky", {31'h0, ee_done}, 32'h1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule